// File: doc/BRIEF.md
# Peripheral DMA Channel Lane

This block is one direction (receive or transfer-out) of a small DMA channel that serves a peripheral. Software writes a base address, a byte count and a control word through a narrow register port. Once started, the lane asks the peripheral for data beats. For every accepted beat it presents the current memory address, then advances the address and lowers the byte count by the beat width of 1, 2 or 4 bytes. It continues until the count is spent and then emits a one-cycle completion pulse.

A second transfer can be queued behind the running one in a one-deep holding slot. That transfer starts on the cycle after the running one finishes, with no idle cycle between them. In auto-restart mode the lane reloads the programmed address and count after each completion and carries on. A clear command drops the running transfer and the queued one. Reading the count register returns the bytes still outstanding. In a full channel two lanes sit side by side, one at channel offset 0x00 and one at 0x10.

Top module: `pdma_lane`

## Requirements
- R1: After reset, beat_req and done are 0 and the control, address and count registers all read 0.
- R2: A control write with bit 4 = 1 and bit 5 = 0 to an idle lane with a nonzero count starts a transfer. From the next cycle beat_req is 1, mem_addr equals the programmed base, and control bit 4 reads 1.
- R3: Control bits 2:1 set the beat width: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Each cycle with beat_req and beat_ack both 1 adds the width to mem_addr and subtracts it from the remaining count. In a cycle without beat_ack, neither value changes.
- R4: The beat on which the remaining count is at or below the width is the last beat. In the next cycle done is 1 for exactly one cycle, beat_req is 0 and control bit 4 reads 0. A count of N bytes therefore takes ceil(N/width) beats.
- R5: A start with a count of 0 on an idle lane raises done in the next cycle and produces no beat request.
- R6: A start with a nonzero count while a transfer runs and the holding slot is empty fills the slot, and control bit 5 reads 1. The queued transfer uses its own address, count and width. It is presented in the cycle right after the last beat of the running one, with beat_req kept at 1, and done is 1 in that same cycle.
- R7: A start while the holding slot is full, or a start with a count of 0 while a transfer runs, is ignored.
- R8: With control bit 0 = 1, each completion reloads the programmed base and count, keeps beat_req at 1 and still pulses done.
- R9: A control write with bit 5 = 1 stops the lane and empties the holding slot. This wins over bit 4 in the same write. From the next cycle beat_req is 0, control bits 4 and 5 read 0, and the count register reads 0.
- R10: The register at offset 0x4 reads the remaining byte count of the running transfer. The register at offset 0x0 reads the current address. The register at offset 0xC reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write byte offset (0x0 base, 0x4 count, 0x8 control, 0xC spare) |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| beat_req | output | 1 | Lane wants a peripheral beat |
| beat_ack | input | 1 | Peripheral accepts the beat this cycle |
| mem_addr | output | 32 | Memory address of the current beat |
| beat_width | output | 2 | Width code of the current beat |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every width code against byte counts from 0 to 12, with beat_ack held high and with beat_ack toggling. A design that rounded the beat count wrongly, moved the address on a stalled cycle, or mishandled width code 3 would show a wrong address or a wrong count at some beat, or a done pulse in the wrong cycle. Queued transfers are tested for the gapless hand-over, where a design with a wrong hand-over would drop beat_req for a cycle or restart at the wrong base. Further tests cover a third start that must not overwrite the slot, the auto-restart loop, and a clear sent together with a start, which must leave the lane idle with no done pulse.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 4;
    localparam int STEP_W = 3;

    // control word bit positions
    localparam int CTL_CONT  = 0;
    localparam int CTL_WLO   = 1;
    localparam int CTL_GO    = 4;
    localparam int CTL_CLR   = 5;

    // word index of each register (byte offset >> 2)
    localparam logic [1:0] IDX_BASE  = 2'd0;
    localparam logic [1:0] IDX_COUNT = 2'd1;
    localparam logic [1:0] IDX_CTL   = 2'd2;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_WALT = 2'd3
    } width_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        width_e            width;
    } xfer_t;

    function automatic logic [STEP_W-1:0] step_of(width_e w);
        case (w)
            W_BYTE:  return STEP_W'(1);
            W_HALF:  return STEP_W'(2);
            default: return STEP_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output xfer_t             prog_o,
    output logic              cont_o,
    output logic              start_o,
    output logic              clear_o
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    width_e            width_q;
    logic              cont_q;
    logic              ctl_wr;

    assign ctl_wr = wr_i && (off_i[OFF_W-1:2] == IDX_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            count_q <= '0;
            width_q <= W_BYTE;
            cont_q  <= 1'b0;
        end else if (wr_i) begin
            case (off_i[OFF_W-1:2])
                IDX_BASE:  base_q  <= wdata_i[ADDR_W-1:0];
                IDX_COUNT: count_q <= wdata_i[CNT_W-1:0];
                IDX_CTL: begin
                    width_q <= width_e'(wdata_i[CTL_WLO+1:CTL_WLO]);
                    cont_q  <= wdata_i[CTL_CONT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        prog_o.addr  = base_q;
        prog_o.left  = count_q;
        prog_o.width = ctl_wr ? width_e'(wdata_i[CTL_WLO+1:CTL_WLO]) : width_q;
    end

    assign cont_o  = cont_q;
    assign clear_o = ctl_wr && wdata_i[CTL_CLR];
    assign start_o = ctl_wr && wdata_i[CTL_GO] && !wdata_i[CTL_CLR];
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              clear_i,
    input  xfer_t             prog_i,
    input  logic              cont_i,
    input  logic              beat_ack_i,
    output logic              busy_o,
    output xfer_t             cur_o,
    output logic              held_o,
    output logic              done_o,
    output logic [STEP_W-1:0] step_o
);
    xfer_t cur_q, cur_n, slot_q, slot_n;
    logic  busy_q, busy_n, held_q, held_n, done_q, done_n;
    logic  fire, last;
    logic [STEP_W-1:0] step;

    assign step = step_of(cur_q.width);
    assign fire = busy_q && beat_ack_i;
    assign last = fire && (cur_q.left <= CNT_W'(step));

    always_comb begin
        cur_n  = cur_q;
        slot_n = slot_q;
        busy_n = busy_q;
        held_n = held_q;
        done_n = 1'b0;
        if (fire) begin
            cur_n.addr = cur_q.addr + ADDR_W'(step);
            cur_n.left = last ? '0 : cur_q.left - CNT_W'(step);
            if (last) begin
                done_n = 1'b1;
                if (held_q) begin
                    cur_n  = slot_q;
                    held_n = 1'b0;
                end else if (cont_i && prog_i.left != '0) begin
                    cur_n = prog_i;
                end else begin
                    busy_n = 1'b0;
                end
            end
        end
        if (start_i) begin
            if (!busy_n) begin
                if (prog_i.left == '0) begin
                    done_n = 1'b1;
                end else begin
                    cur_n  = prog_i;
                    busy_n = 1'b1;
                end
            end else if (!held_n && prog_i.left != '0) begin
                slot_n = prog_i;
                held_n = 1'b1;
            end
        end
        if (clear_i) begin
            busy_n     = 1'b0;
            held_n     = 1'b0;
            done_n     = 1'b0;
            cur_n.left = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            slot_q <= '0;
            busy_q <= 1'b0;
            held_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cur_q  <= cur_n;
            slot_q <= slot_n;
            busy_q <= busy_n;
            held_q <= held_n;
            done_q <= done_n;
        end
    end

    assign busy_o = busy_q;
    assign cur_o  = cur_q;
    assign held_o = held_q;
    assign done_o = done_q;
    assign step_o = step;
endmodule

// File: rtl/pdma_lane.sv
module pdma_lane
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [OFF_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              beat_req,
    input  logic              beat_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        beat_width,
    output logic              done
);
    xfer_t             prog, cur;
    logic              cont, start_p, clear_p, busy, held;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  cur_left;
    logic [1:0]        cfg_width;

    pdma_regs u_regs (
        .clk(clk), .rst(rst), .wr_i(reg_wr), .off_i(reg_addr), .wdata_i(reg_wdata),
        .prog_o(prog), .cont_o(cont), .start_o(start_p), .clear_o(clear_p)
    );

    pdma_engine u_eng (
        .clk(clk), .rst(rst), .start_i(start_p), .clear_i(clear_p), .prog_i(prog),
        .cont_i(cont), .beat_ack_i(beat_ack), .busy_o(busy), .cur_o(cur),
        .held_o(held), .done_o(done), .step_o(step)
    );

    assign cur_left   = cur.left;
    assign beat_req   = busy;
    assign mem_addr   = cur.addr;
    assign beat_width = cur.width;
    assign cfg_width  = prog.width;

    always_comb begin
        rd_data = '0;
        case (rd_addr[OFF_W-1:2])
            IDX_BASE:  rd_data = DATA_W'(cur.addr);
            IDX_COUNT: rd_data = DATA_W'(cur.left);
            IDX_CTL: begin
                rd_data[CTL_CONT]              = cont;
                rd_data[CTL_WLO+1:CTL_WLO]     = cfg_width;
                rd_data[CTL_GO]                = busy;
                rd_data[CTL_CLR]               = held;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pdma_lane_chk.sv
module pdma_lane_chk
    import pdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              beat_req,
    input logic              beat_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  left,
    input logic [STEP_W-1:0] step,
    input logic              clr,
    input logic              held,
    input logic              done
);
    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_req && beat_ack && left > CNT_W'(step) && !clr)
        |=> (mem_addr == $past(mem_addr) + ADDR_W'($past(step))));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_req && !beat_ack && !clr) |=> ($stable(mem_addr) && $stable(left)));

    // R4
    last_done_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_req && beat_ack && left <= CNT_W'(step) && !clr) |=> done);

    // R6
    slot_busy_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> beat_req);

    // R9
    clear_stop_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!beat_req && !held && !done));
endmodule

bind pdma_lane pdma_lane_chk u_chk (
    .clk(clk), .rst(rst), .beat_req(beat_req), .beat_ack(beat_ack),
    .mem_addr(mem_addr), .left(cur_left), .step(step), .clr(clear_p),
    .held(held), .done(done)
);

// File: tb/tb_pdma_lane.sv
module tb_pdma_lane;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        beat_req, beat_ack, done;
    logic [31:0] mem_addr;
    logic [1:0]  beat_width;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pdma_lane dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .beat_req(beat_req), .beat_ack(beat_ack),
        .mem_addr(mem_addr), .beat_width(beat_width), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic int step_for(int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    // one full transfer from idle; pat 0 = ack always, 1 = ack on odd cycles
    task automatic run_xfer(input int code, input int size, input int pat);
        logic [31:0] base, v;
        int st, nb, k, cyc;
        st = step_for(code);
        nb = (size + st - 1) / st;
        base = 32'h1000 + code * 32'h100 + size * 32'h10;
        wr(4'h0, base);
        wr(4'h4, size);
        wr(4'h8, 32'h10 | (code << 1));
        if (size == 0) begin
            chk("R5 done on zero count", done, 1);
            chk("R5 no beat on zero count", beat_req, 0);
            @(negedge clk);
            chk("R5 done one cycle", done, 0);
        end else begin
            rd(4'h8, v);
            chk("R2 busy bit", v[4], 1);
            k = 0; cyc = 0;
            while (k < nb) begin
                chk("R2 beat_req while active", beat_req, 1);
                chk("R3 beat address", mem_addr, base + k * st);
                rd(4'h4, v);
                chk("R10 remaining count", v, size - k * st);
                chk("R4 no early done", done, 0);
                beat_ack = (pat == 0) || cyc[0];
                @(negedge clk);
                if (beat_ack) k++;
                cyc++;
                beat_ack = 1'b0;
            end
            chk("R4 done after last beat", done, 1);
            chk("R4 beat_req drops", beat_req, 0);
            rd(4'h8, v);
            chk("R4 busy bit clears", v[4], 0);
            @(negedge clk);
            chk("R4 done single cycle", done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rd_addr = '0; beat_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 beat_req reset", beat_req, 0);
        chk("R1 done reset", done, 0);
        rd(4'h8, v); chk("R1 control reset", v, 0);
        rd(4'h4, v); chk("R1 count reset", v, 0);
        rd(4'h0, v); chk("R1 address reset", v, 0);

        // sweep of widths, counts and ack patterns
        for (int code = 0; code < 4; code++)
            for (int size = 0; size < 13; size++)
                for (int pat = 0; pat < 2; pat++)
                    run_xfer(code, size, pat);

        rd(4'hC, v); chk("R10 spare reads zero", v, 0);

        // queued transfer behind a running one
        wr(4'h0, 32'h2000); wr(4'h4, 8); wr(4'h8, 32'h14);
        wr(4'h0, 32'h3000); wr(4'h4, 4); wr(4'h8, 32'h10);
        rd(4'h8, v); chk("R6 slot bit set", v[5], 1);
        wr(4'h0, 32'h4000); wr(4'h4, 2); wr(4'h8, 32'h10);
        chk("R7 running base untouched", mem_addr, 32'h2000);
        beat_ack = 1'b1;
        @(negedge clk); chk("R3 word step", mem_addr, 32'h2004);
        @(negedge clk);
        chk("R6 gapless hand-over", beat_req, 1);
        chk("R6 done at hand-over", done, 1);
        chk("R7 queued base kept", mem_addr, 32'h3000);
        rd(4'h8, v); chk("R6 slot bit clears", v[5], 0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); chk("R6 queued byte step", mem_addr, 32'h3000 + i);
        end
        @(negedge clk);
        chk("R7 third start not run", beat_req, 0);
        chk("R6 queued done", done, 1);
        beat_ack = 1'b0;

        // zero count while running is ignored
        wr(4'h0, 32'h5000); wr(4'h4, 4); wr(4'h8, 32'h10);
        wr(4'h4, 0); wr(4'h8, 32'h10);
        rd(4'h8, v); chk("R7 zero count not queued", v[5], 0);

        // clear wins over start
        wr(4'h8, 32'h30);
        chk("R9 clear stops", beat_req, 0);
        chk("R9 no done on clear", done, 0);
        rd(4'h8, v); chk("R9 control bits 4 and 5", v[5:4], 0);
        rd(4'h4, v); chk("R9 count cleared", v, 0);

        // auto-restart
        wr(4'h0, 32'h6000); wr(4'h4, 4); wr(4'h8, 32'h13);
        beat_ack = 1'b1;
        for (int lap = 0; lap < 3; lap++) begin
            chk("R8 lap base", mem_addr, 32'h6000);
            @(negedge clk); chk("R8 lap second beat", mem_addr, 32'h6002);
            @(negedge clk);
            chk("R8 done each lap", done, 1);
            chk("R8 beat_req stays", beat_req, 1);
        end
        beat_ack = 1'b0;
        wr(4'h8, 32'h20);
        chk("R9 clear ends restart", beat_req, 0);
        @(negedge clk);
        chk("R9 stays idle", beat_req, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule